// File: doc/BRIEF.md
# Dual-Channel Serial Converter Interface Emulator

This block stands in for a two-channel, 12-bit serial analog-to-digital converter on a test FPGA. The host logic presents two parallel sample words, one per channel. An external controller drives an active-low chip select and a serial clock. The block shifts the two words out on two separate data lines, as the real converter would.

Both external control pins are asynchronous to the system clock. Each passes through a two-stage synchroniser, and all edge detection runs on the synchronised levels. Each 16-clock word opens with an acquisition phase and continues with a conversion phase. Both parallel inputs are captured together at the boundary between the two phases. While chip select stays low, this cycle repeats back to back. The data lines are enabled only while chip select is low. A phase code and a bit position are exported so that a bench can follow the device state.

Top module: `dual_adc_serial_emu`

## Requirements
- R1: `sdo_oe_a` and `sdo_oe_b` are 1 while the synchronised chip select is low and 0 while it is high. Whenever the enables are 0, both data lines read 0.
- R2: Each word takes 16 effective falling clock edges. After falling edge k (1..16), both lanes show 0 for k ≤ 4 and sample bit 16−k for k ≥ 5, so the most significant bit comes first.
- R3: If chip select falls while the serial clock is high, nothing is counted until the next falling clock edge. Until then `bit_pos` is 0 and `phase` is idle.
- R4: If chip select falls while the serial clock is low, that fall counts as falling edge 1: `bit_pos` becomes 1 and `phase` becomes acquisition.
- R5: If chip select and the serial clock fall together, exactly one falling edge is counted and acquisition starts.
- R6: Both channel inputs are captured together at falling edge 4. Changing the inputs after that edge has no effect on the rest of the word.
- R7: `phase` uses 0 for idle, 1 for acquisition and 2 for conversion. It is 1 after falling edges 1..3 and 2 from falling edge 4 up to the 16th rising edge. After the 16th rising edge it returns to 1.
- R8: While chip select stays low, words repeat without a gap. `bit_pos` holds the count of falling edges in the current word modulo 16, so edge 16 reads 0. It only ever steps by one or clears to 0.
- R9: A rising chip select in the middle of a word abandons that word: `bit_pos` becomes 0, `phase` becomes idle and the enables drop. The next frame starts again from edge 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select from the external controller, asynchronous, active low |
| sclk | input | 1 | Serial clock from the external controller, asynchronous |
| sample_a | input | 12 | Parallel sample word for channel A |
| sample_b | input | 12 | Parallel sample word for channel B |
| sdo_a | output | 1 | Serial data for channel A |
| sdo_b | output | 1 | Serial data for channel B |
| sdo_oe_a | output | 1 | Output enable for the channel A data line |
| sdo_oe_b | output | 1 | Output enable for the channel B data line |
| phase | output | 2 | Device phase: 0 idle, 1 acquisition, 2 conversion |
| bit_pos | output | 4 | Falling edges in the current word, modulo 16 |

## Verification
The checker asserts the following on every cycle:
- the enables and phase agree with each other;
- the data lines are silent while the enables are off;
- the lead-in bits are zero;
- the bit counter only steps by one or clears;
- each phase stays inside its own range of bit positions.

Other behaviours depend on what the external controller does, so only the bench scenarios can show them:
- the three start conditions;
- the actual bit values shifted out;
- the capture point of the samples;
- the return to acquisition after the 16th rising edge;
- the abort on a mid-word chip-select rise.

// File: rtl/adcemu_pkg.sv
package adcemu_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACQ  = 2'd1,
        PH_CONV = 2'd2
    } phase_e;

    // Per-edge command from the frame controller to each lane
    typedef struct packed {
        logic clear;   // frame inactive: silence the line
        logic load;    // capture the parallel sample (also a zero bit)
        logic zero;    // lead-in zero bit
        logic shift;   // present the next result bit
    } lane_cmd_t;

endpackage

// File: rtl/adcemu_sync.sv
module adcemu_sync #(
    parameter int           W       = 2,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/adcemu_frame_ctl.sv
module adcemu_frame_ctl
    import adcemu_pkg::*;
#(
    parameter int WORD_LEN   = 16,
    parameter int LEAD_ZEROS = 4,
    parameter int CNT_W      = $clog2(WORD_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_s,
    input  logic             sclk_s,
    output lane_cmd_t        cmd,
    output logic             oe,
    output phase_e           phase,
    output logic [CNT_W-1:0] bit_pos
);

    typedef struct packed {
        logic             cs_prev;
        logic             sclk_prev;
        logic             oe;
        logic [CNT_W-1:0] cnt;
        phase_e           phase;
    } ctl_t;

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LEAD_ZEROS);

    ctl_t             st_d, st_q;
    logic             cs_act, cs_fall, sclk_fall, sclk_rise;
    logic             eff_fall, eff_rise;
    logic [CNT_W-1:0] cnt_n;

    always_comb begin
        cs_act    = ~cs_n_s;
        cs_fall   = st_q.cs_prev & ~cs_n_s;
        sclk_fall = st_q.sclk_prev & ~sclk_s;
        sclk_rise = ~st_q.sclk_prev & sclk_s;

        // A chip-select fall with the clock already low stands in for the
        // first falling clock edge; a simultaneous fall counts only once.
        eff_fall  = (cs_fall & ~sclk_s) | (cs_act & ~cs_fall & sclk_fall);
        eff_rise  = cs_act & ~cs_fall & sclk_rise;

        cnt_n     = (st_q.cnt == CNT_LAST) ? '0 : st_q.cnt + CNT_W'(1);

        st_d           = st_q;
        st_d.cs_prev   = cs_n_s;
        st_d.sclk_prev = sclk_s;
        st_d.oe        = cs_act;

        cmd       = '0;
        cmd.clear = ~cs_act;

        if (!cs_act) begin
            st_d.cnt   = '0;
            st_d.phase = PH_IDLE;
        end else if (eff_fall) begin
            st_d.cnt = cnt_n;
            if (cnt_n >= CNT_LOAD || cnt_n == '0) begin
                st_d.phase = PH_CONV;
            end else begin
                st_d.phase = PH_ACQ;
            end
            cmd.load  = (cnt_n == CNT_LOAD);
            cmd.zero  = (cnt_n != '0) && (cnt_n < CNT_LOAD);
            cmd.shift = (cnt_n > CNT_LOAD) || (cnt_n == '0);
        end else if (eff_rise && st_q.cnt == '0 && st_q.phase == PH_CONV) begin
            // last rising edge of a word: back to acquisition
            st_d.phase = PH_ACQ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cs_prev: 1'b1, sclk_prev: 1'b0, oe: 1'b0,
                      cnt: '0, phase: PH_IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    assign oe      = st_q.oe;
    assign phase   = st_q.phase;
    assign bit_pos = st_q.cnt;

endmodule

// File: rtl/adcemu_lane.sv
module adcemu_lane
    import adcemu_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  lane_cmd_t           cmd,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                sdo
);

    typedef struct packed {
        logic [SAMPLE_W-1:0] shreg;
        logic                sdo;
    } lane_t;

    lane_t ln_d, ln_q;

    always_comb begin
        ln_d = ln_q;
        if (cmd.clear) begin
            ln_d.sdo = 1'b0;
        end else if (cmd.load) begin
            ln_d.shreg = sample;
            ln_d.sdo   = 1'b0;
        end else if (cmd.zero) begin
            ln_d.sdo = 1'b0;
        end else if (cmd.shift) begin
            ln_d.sdo   = ln_q.shreg[SAMPLE_W-1];
            ln_d.shreg = {ln_q.shreg[SAMPLE_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign sdo = ln_q.sdo;

endmodule

// File: rtl/dual_adc_serial_emu.sv
module dual_adc_serial_emu
    import adcemu_pkg::*;
#(
    parameter int SAMPLE_W    = 12,
    parameter int LEAD_ZEROS  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic [SAMPLE_W-1:0] sample_a,
    input  logic [SAMPLE_W-1:0] sample_b,
    output logic                sdo_a,
    output logic                sdo_b,
    output logic                sdo_oe_a,
    output logic                sdo_oe_b,
    output logic [1:0]          phase,
    output logic [$clog2(SAMPLE_W+LEAD_ZEROS)-1:0] bit_pos
);

    localparam int WORD_LEN = SAMPLE_W + LEAD_ZEROS;
    localparam int CNT_W    = $clog2(WORD_LEN);
    localparam int NUM_CH   = 2;

    logic [1:0]                      pins_s;
    lane_cmd_t                       cmd;
    logic                            oe;
    phase_e                          ph;
    logic [NUM_CH-1:0][SAMPLE_W-1:0] samples;
    logic [NUM_CH-1:0]               sdo_v;

    // bit 1: chip select (idles high), bit 0: serial clock
    adcemu_sync #(
        .W       (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n, sclk}),
        .sync_o  (pins_s)
    );

    adcemu_frame_ctl #(
        .WORD_LEN   (WORD_LEN),
        .LEAD_ZEROS (LEAD_ZEROS),
        .CNT_W      (CNT_W)
    ) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (pins_s[1]),
        .sclk_s  (pins_s[0]),
        .cmd     (cmd),
        .oe      (oe),
        .phase   (ph),
        .bit_pos (bit_pos)
    );

    assign samples[0] = sample_a;
    assign samples[1] = sample_b;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        adcemu_lane #(
            .SAMPLE_W (SAMPLE_W)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmd    (cmd),
            .sample (samples[ch]),
            .sdo    (sdo_v[ch])
        );
    end

    assign sdo_a    = sdo_v[0];
    assign sdo_b    = sdo_v[1];
    assign sdo_oe_a = oe;
    assign sdo_oe_b = oe;
    assign phase    = ph;

endmodule

// File: rtl/adcemu_checker.sv
module adcemu_checker #(
    parameter int CNT_W      = 4,
    parameter int LEAD_ZEROS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sdo_a,
    input logic             sdo_b,
    input logic             sdo_oe_a,
    input logic             sdo_oe_b,
    input logic [1:0]       phase,
    input logic [CNT_W-1:0] bit_pos
);

    localparam logic [1:0] P_IDLE = 2'd0;
    localparam logic [1:0] P_ACQ  = 2'd1;
    localparam logic [1:0] P_CONV = 2'd2;

    a_r1_lanes_enabled_together: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe_a == sdo_oe_b);

    a_r1_silent_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe_a |-> (!sdo_a && !sdo_b));

    a_r9_active_phase_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != P_IDLE) |-> sdo_oe_a);

    a_r9_idle_counter_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == P_IDLE) |-> (bit_pos == '0));

    a_r2_lead_in_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_pos != '0 && bit_pos <= CNT_W'(LEAD_ZEROS)) |-> (!sdo_a && !sdo_b));

    a_r8_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_pos != $past(bit_pos)) |-> (bit_pos == $past(bit_pos) + CNT_W'(1) || bit_pos == '0));

    a_r7_acq_range: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == P_ACQ) |-> (bit_pos < CNT_W'(LEAD_ZEROS)));

    a_r7_conv_range: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == P_CONV) |-> (bit_pos >= CNT_W'(LEAD_ZEROS) || bit_pos == '0));

    a_r7_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 2'd3);

endmodule

bind dual_adc_serial_emu adcemu_checker #(
    .CNT_W      (CNT_W),
    .LEAD_ZEROS (LEAD_ZEROS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sdo_a    (sdo_a),
    .sdo_b    (sdo_b),
    .sdo_oe_a (sdo_oe_a),
    .sdo_oe_b (sdo_oe_b),
    .phase    (phase),
    .bit_pos  (bit_pos)
);

// File: tb/dual_adc_serial_emu_tb.sv
`timescale 1ns/1ps
module dual_adc_serial_emu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic [11:0] sample_a = '0;
    logic [11:0] sample_b = '0;
    logic        sdo_a, sdo_b, sdo_oe_a, sdo_oe_b;
    logic [1:0]  phase;
    logic [3:0]  bit_pos;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dual_adc_serial_emu u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .sample_a (sample_a),
        .sample_b (sample_b),
        .sdo_a    (sdo_a),
        .sdo_b    (sdo_b),
        .sdo_oe_a (sdo_oe_a),
        .sdo_oe_b (sdo_oe_b),
        .phase    (phase),
        .bit_pos  (bit_pos)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_bit(input logic [11:0] w, input int k);
        return (k <= 4) ? 0 : int'(w[16-k]);
    endfunction

    function automatic int exp_phase_fall(input int k);
        return (k >= 4) ? 2 : 1;
    endfunction

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic step_sclk(input logic v);
        @(negedge clk);
        sclk = v;
        settle();
    endtask

    task automatic chk_fall(input logic [11:0] a, input logic [11:0] b, input int k);
        chk("R2 sdo_a bit", int'(sdo_a), exp_bit(a, k));
        chk("R2 sdo_b bit", int'(sdo_b), exp_bit(b, k));
        chk("R8 bit_pos after fall", int'(bit_pos), k % 16);
        chk("R7 phase after fall", int'(phase), exp_phase_fall(k));
        chk("R1 enable in frame", int'(sdo_oe_a & sdo_oe_b), 1);
    endtask

    // one 16-clock word; inputs a,b must already be on sample_a/sample_b
    task automatic run_word(input logic [11:0] a, input logic [11:0] b, input bit first_done);
        for (int k = 1; k <= 16; k++) begin
            if (!(k == 1 && first_done)) step_sclk(1'b0);
            chk_fall(a, b, k);
            if (k == 4) begin
                // R6: inputs change after capture; output must keep old word
                sample_a = 12'($urandom);
                sample_b = 12'($urandom);
            end
            step_sclk(1'b1);
            chk("R7 phase after rise", int'(phase), (k == 16) ? 1 : exp_phase_fall(k));
            chk("R8 bit_pos after rise", int'(bit_pos), k % 16);
        end
    endtask

    task automatic start_frame(input int mode);
        if (mode == 1) step_sclk(1'b0);
        else           step_sclk(1'b1);
        @(negedge clk);
        cs_n = 1'b0;
        if (mode == 2) sclk = 1'b0;
        settle();
        if (mode == 0) begin
            chk("R3 bit_pos waits for fall", int'(bit_pos), 0);
            chk("R3 phase idle before fall", int'(phase), 0);
            chk("R1 enable on select", int'(sdo_oe_a), 1);
        end else if (mode == 1) begin
            chk("R4 select fall counts as edge", int'(bit_pos), 1);
            chk("R4 acquisition started", int'(phase), 1);
        end else begin
            chk("R5 simultaneous fall counted once", int'(bit_pos), 1);
            chk("R5 acquisition started", int'(phase), 1);
        end
    endtask

    task automatic end_frame();
        @(negedge clk);
        cs_n = 1'b1;
        settle();
        chk("R1 enable off", int'(sdo_oe_a | sdo_oe_b), 0);
        chk("R1 lines silent", int'(sdo_a | sdo_b), 0);
        chk("R9 phase idle", int'(phase), 0);
        chk("R9 bit_pos clear", int'(bit_pos), 0);
    endtask

    task automatic do_frame(input int mode, input int nwords,
                            input logic [11:0] a0, input logic [11:0] b0);
        logic [11:0] a, b;
        a = a0;
        b = b0;
        sample_a = a;
        sample_b = b;
        start_frame(mode);
        for (int w = 0; w < nwords; w++) begin
            if (w != 0) begin
                a = 12'($urandom);
                b = 12'($urandom);
                sample_a = a;
                sample_b = b;
            end
            run_word(a, b, (w == 0) && (mode != 0));
        end
        end_frame();
    endtask

    task automatic abort_frame();
        logic [11:0] a, b;
        a = 12'h6D3;
        b = 12'h92C;
        sample_a = a;
        sample_b = b;
        start_frame(0);
        for (int k = 1; k <= 7; k++) begin
            step_sclk(1'b0);
            chk_fall(a, b, k);
            if (k != 7) step_sclk(1'b1);
        end
        @(negedge clk);
        cs_n = 1'b1;
        settle();
        chk("R9 abort clears bit_pos", int'(bit_pos), 0);
        chk("R9 abort phase idle", int'(phase), 0);
        chk("R9 abort drops enable", int'(sdo_oe_a | sdo_oe_b), 0);
        // next frame starts cleanly from edge 1
        do_frame(0, 1, 12'h0F0, 12'hF0F);
    endtask

    initial begin
        void'($urandom(32'd20240517));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk("R1 reset enable off", int'(sdo_oe_a | sdo_oe_b), 0);
        chk("R9 reset phase idle", int'(phase), 0);
        chk("R8 reset bit_pos", int'(bit_pos), 0);
        chk("R1 reset lines low", int'(sdo_a | sdo_b), 0);

        // directed corner cases
        do_frame(0, 2, 12'hA5C, 12'h3F1);
        do_frame(1, 1, 12'hFFF, 12'h000);
        do_frame(2, 2, 12'h800, 12'h001);
        abort_frame();

        // random frames
        for (int f = 0; f < 20; f++) begin
            do_frame(int'($urandom % 3), 1 + int'($urandom % 3),
                     12'($urandom), 12'($urandom));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule